// File: doc/BRIEF.md
# Tagged Address Translation Buffer with Access Checking

This block is a small, fully associative cache of page mappings. A lookup presents a virtual address and an access kind (load, store or instruction fetch). In the same cycle the block answers with exactly one of three outcomes. A hit gives the physical address. A miss tells the refill logic or the trap handler that no mapping is held. A protection fault means a mapping exists but does not allow this kind of access.

Each entry holds a virtual page number, a frame number and an address-space tag. It also holds permission bits for store and fetch, and valid, dirty and referenced bits. A lookup compares the tag with a current-process register, so mappings from different processes can stay side by side. A single flush input can also drop every mapping at once. Entries are written through a refill port, either by software after a miss or by a hardware table walker. The refill port picks the slot by itself.

Top module: `tlb_prot_xlate`

## Requirements
- R1: After reset every entry is invalid, the process register is 0 and every lookup reports a miss.
- R2: A lookup with `lk_valid` high matches an entry only when that entry is valid, its page number equals `lk_vaddr[VA_W-1:OFF_W]` and its tag equals the current process register.
- R3: On a hit, `lk_paddr` is the stored frame number in the upper bits, joined with `lk_vaddr[OFF_W-1:0]` unchanged in the lower bits.
- R4: When no entry matches, `lk_miss` is 1, and `lk_hit`, `lk_fault`, `lk_paddr`, `lk_way`, `lk_dirty` and `lk_ref` are 0.
- R5: The `lk_acc` encoding is 0 for load, 1 for store, 2 for fetch and 3 for load. A load is always permitted. A store needs the entry's store-permission bit and a fetch needs its fetch-permission bit. A matching access that is not permitted gives `lk_fault`=1 and `lk_hit`=0, with `lk_paddr`=0.
- R6: At the clock edge that ends a hit, the entry's referenced bit is set, and a store hit also sets its dirty bit. A fault sets neither bit. `lk_dirty` and `lk_ref` show the matched entry's bits as they were before the current access. A refill clears both bits.
- R7: `flush_all` invalidates every entry at the next edge. A refill in the same cycle still lands, and its entry stays valid.
- R8: `pid_we` loads `pid_in` into the current process register at the next edge. Entries with another tag then miss, and they match again once their tag is restored.
- R9: The refill slot is chosen in this order. First, the entry already holding the same page and tag, which is overwritten. Otherwise, the lowest-indexed invalid entry. Otherwise, the entry under a rotating pointer, which starts at 0 and advances by one, wrapping, only when it is used.
- R10: `lk_way` reports the index of the matched entry on a hit or a fault. If several entries match, the lowest index wins.
- R11: A refill becomes visible at the edge that ends its cycle. A lookup in the same cycle sees the old contents, and a refill overwrites any status update that a lookup makes to the same entry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pid_we | input | 1 | Load the current process register |
| pid_in | input | PID_W | New process identifier |
| flush_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry forbids this access |
| lk_paddr | output | PA_W | Physical address on a hit, else 0 |
| lk_way | output | IDX_W | Index of the matched entry |
| lk_dirty | output | 1 | Dirty bit of the matched entry, before this access |
| lk_ref | output | 1 | Referenced bit of the matched entry, before this access |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VA_W-OFF_W | Page number to install |
| rf_pfn | input | PA_W-OFF_W | Frame number to install |
| rf_pid | input | PID_W | Process tag to install |
| rf_store_ok | input | 1 | Store permission for the new entry |
| rf_fetch_ok | input | 1 | Fetch permission for the new entry |

## Verification
The two functions that can collide are a refill and a flush, and also a refill and a lookup that updates status bits. Both pairs are driven in the same cycle. In the first case, the bench sets `flush_all` and `rf_valid` together while every slot is full. It then sweeps the page range and expects only the refilled page to hit, at the slot given by the rotating pointer. In the second case, a lookup and a refill of the same page share a cycle. The lookup must miss, and the next cycle must hit with clean status bits.

// File: rtl/tlb_pkg.sv
// Package: shared access-kind encoding and the permission rule.
// Assumes: lk_acc encoding 0 load, 1 store, 2 fetch, 3 treated as load.
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    // Decide whether an access kind is allowed by an entry's permission bits.
    function automatic logic access_allowed(acc_e kind, logic store_ok, logic fetch_ok);
        case (kind)
            ACC_STORE: return store_ok;
            ACC_FETCH: return fetch_ok;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tlb_prio_enc.sv
// Module: lowest-index-first priority encoder.
// Assumes: N >= 2; idx is 0 when no request bit is set.
module tlb_prio_enc #(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so that the lowest set bit is written last and wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    // Flag that any request is present.
    assign found = |req;

endmodule

// File: rtl/tlb_tag_cam.sv
// Module: parallel compare of a page/tag key against every entry.
// Assumes: entry arrays are packed, index 0 in the low slice.
module tlb_tag_cam #(
    parameter int N     = 64,
    parameter int VPN_W = 20,
    parameter int PID_W = 8
) (
    input  logic [N-1:0]            ent_valid,
    input  logic [N-1:0][VPN_W-1:0] ent_vpn,
    input  logic [N-1:0][PID_W-1:0] ent_pid,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [PID_W-1:0]        key_pid,
    output logic [N-1:0]            match
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        // One comparator per entry: valid, page and tag must all agree.
        assign match[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) && (ent_pid[g] == key_pid);
    end

endmodule

// File: rtl/tlb_victim_sel.sv
// Module: picks the slot a refill writes.
// Order: existing same page/tag, else lowest invalid, else rotating pointer.
// Assumes: synchronous active-low reset; pointer moves only when it is used.
module tlb_victim_sel #(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ent_valid,
    input  logic          dup_found,
    input  logic [IW-1:0] dup_idx,
    input  logic          alloc,
    output logic [IW-1:0] victim
);

    logic          free_found;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] rr_q;
    logic          use_rr;

    tlb_prio_enc #(.N(N)) u_free (
        .req   (~ent_valid),
        .found (free_found),
        .idx   (free_idx)
    );

    // Flag that the rotating pointer supplies this refill's slot.
    assign use_rr = !dup_found && !free_found;

    // Choose the refill slot by the fixed precedence.
    always_comb begin
        if (dup_found)       victim = dup_idx;
        else if (free_found) victim = free_idx;
        else                 victim = rr_q;
    end

    // Advance the rotating pointer only when a refill consumed it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (alloc && use_rr) begin
            rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    AST_RR_MOVES_ONLY_ON_USE: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc && use_rr) |=> $stable(rr_q)); // R9

endmodule

// File: rtl/tlb_prot_xlate.sv
// Module: tagged, fully associative translation buffer with access checking.
// Lookup is combinational from stored state; refill, flush, process
// register and status-bit updates all take effect at the next clock edge.
// Assumes: synchronous active-low reset; OFF_W < VA_W and OFF_W < PA_W.
module tlb_prot_xlate #(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PID_W   = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PFN_W  = PA_W - OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pid_we,
    input  logic [PID_W-1:0] pid_in,
    input  logic             flush_all,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    output logic [IDX_W-1:0] lk_way,
    output logic             lk_dirty,
    output logic             lk_ref,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PFN_W-1:0] rf_pfn,
    input  logic [PID_W-1:0] rf_pid,
    input  logic             rf_store_ok,
    input  logic             rf_fetch_ok
);

    import tlb_pkg::*;

    // Entry storage.
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0]            dirty_q;
    logic [ENTRIES-1:0]            ref_q;
    logic [ENTRIES-1:0]            st_ok_q;
    logic [ENTRIES-1:0]            fe_ok_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    logic [ENTRIES-1:0][PID_W-1:0] pid_q;
    logic [PID_W-1:0]              cur_pid_q;

    // Lookup path.
    acc_e               acc;
    logic [VPN_W-1:0]   lk_vpn;
    logic [OFF_W-1:0]   lk_off;
    logic [ENTRIES-1:0] lk_match;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic               lk_perm;
    logic               lk_found;

    // Refill path.
    logic [ENTRIES-1:0] rf_match;
    logic               rf_dup;
    logic [IDX_W-1:0]   rf_dup_idx;
    logic [IDX_W-1:0]   rf_slot;

    assign acc    = acc_e'(lk_acc);
    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    tlb_tag_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_cam (
        .ent_valid (valid_q),
        .ent_vpn   (vpn_q),
        .ent_pid   (pid_q),
        .key_vpn   (lk_vpn),
        .key_pid   (cur_pid_q),
        .match     (lk_match)
    );

    tlb_prio_enc #(.N(ENTRIES)) u_lk_pick (
        .req   (lk_match),
        .found (lk_any),
        .idx   (lk_idx)
    );

    tlb_tag_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_rf_cam (
        .ent_valid (valid_q),
        .ent_vpn   (vpn_q),
        .ent_pid   (pid_q),
        .key_vpn   (rf_vpn),
        .key_pid   (rf_pid),
        .match     (rf_match)
    );

    tlb_prio_enc #(.N(ENTRIES)) u_rf_pick (
        .req   (rf_match),
        .found (rf_dup),
        .idx   (rf_dup_idx)
    );

    tlb_victim_sel #(.N(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (valid_q),
        .dup_found (rf_dup),
        .dup_idx   (rf_dup_idx),
        .alloc     (rf_valid),
        .victim    (rf_slot)
    );

    // Qualify a match with the request strobe and check permissions.
    assign lk_found = lk_valid && lk_any;
    assign lk_perm  = access_allowed(acc, st_ok_q[lk_idx], fe_ok_q[lk_idx]);

    // Produce the single-cycle lookup response.
    always_comb begin
        lk_hit   = lk_found && lk_perm;
        lk_fault = lk_found && !lk_perm;
        lk_miss  = lk_valid && !lk_any;
        lk_paddr = lk_hit ? {pfn_q[lk_idx], lk_off} : '0;
        lk_way   = lk_found ? lk_idx : '0;
        lk_dirty = lk_found && dirty_q[lk_idx];
        lk_ref   = lk_found && ref_q[lk_idx];
    end

    // Hold the current process identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_pid_q <= '0;
        else if (pid_we) cur_pid_q <= pid_in;
    end

    // Update entries: status on hit, then flush, then refill (last wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ref_q   <= '0;
            st_ok_q <= '0;
            fe_ok_q <= '0;
            vpn_q   <= '0;
            pfn_q   <= '0;
            pid_q   <= '0;
        end else begin
            if (lk_hit) begin
                ref_q[lk_idx] <= 1'b1;
                if (acc == ACC_STORE) dirty_q[lk_idx] <= 1'b1;
            end
            if (flush_all) valid_q <= '0;
            if (rf_valid) begin
                valid_q[rf_slot] <= 1'b1;
                dirty_q[rf_slot] <= 1'b0;
                ref_q[rf_slot]   <= 1'b0;
                st_ok_q[rf_slot] <= rf_store_ok;
                fe_ok_q[rf_slot] <= rf_fetch_ok;
                vpn_q[rf_slot]   <= rf_vpn;
                pfn_q[rf_slot]   <= rf_pfn;
                pid_q[rf_slot]   <= rf_pid;
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1); // R4
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_paddr == '0 && !lk_dirty && !lk_ref)); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]); // R3
    AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !rf_valid) |=> valid_q == '0); // R7
    AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |=> valid_q[$past(rf_slot)]); // R11
    AST_PID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pid_we |=> $stable(cur_pid_q)); // R8

endmodule

// File: tb/tlb_prot_xlate_bench.sv
module tlb_prot_xlate_bench;

    localparam int N = 8, VA = 16, PA = 16, OFF = 8, PW = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        pid_we = 0;
    logic [3:0]  pid_in = 0;
    logic        flush_all = 0;
    logic        lk_valid = 0;
    logic [15:0] lk_vaddr = 0;
    logic [1:0]  lk_acc = 0;
    logic        lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref;
    logic [15:0] lk_paddr;
    logic [2:0]  lk_way;
    logic        rf_valid = 0;
    logic [7:0]  rf_vpn = 0, rf_pfn = 0;
    logic [3:0]  rf_pid = 0;
    logic        rf_store_ok = 0, rf_fetch_ok = 0;

    int n_chk = 0, n_fail = 0;

    // Bench model of the contents.
    bit       m_v[N], m_d[N], m_r[N], m_w[N], m_x[N];
    bit [7:0] m_vpn[N], m_pfn[N];
    bit [3:0] m_pid[N];
    bit [3:0] m_cur = 0;
    int       m_rr = 0;

    tlb_prot_xlate #(.ENTRIES(N), .VA_W(VA), .PA_W(PA), .OFF_W(OFF), .PID_W(PW)) u_tlb_prot_xlate (
        .clk(clk), .rst_n(rst_n), .pid_we(pid_we), .pid_in(pid_in), .flush_all(flush_all),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .lk_way(lk_way), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_pid(rf_pid),
        .rf_store_ok(rf_store_ok), .rf_fetch_ok(rf_fetch_ok)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input bit [7:0] vpn, input bit [3:0] pid);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
        return -1;
    endfunction

    function automatic bit m_perm(input int i, input bit [1:0] acc);
        if (acc == 2'd1) return m_w[i];
        if (acc == 2'd2) return m_x[i];
        return 1'b1;
    endfunction

    // One cycle with any mix of lookup, refill and flush; lookup checked before the edge.
    task automatic cyc(input bit dl, input bit [15:0] va, input bit [1:0] acc,
                       input bit dr, input bit [7:0] rv, input bit [7:0] rp, input bit [3:0] rid,
                       input bit rw, input bit rx, input bit fl, input string req);
        int  idx, vic;
        bit  ok;
        @(negedge clk);
        lk_valid = dl; lk_vaddr = va; lk_acc = acc;
        rf_valid = dr; rf_vpn = rv; rf_pfn = rp; rf_pid = rid; rf_store_ok = rw; rf_fetch_ok = rx;
        flush_all = fl;
        #1;
        idx = m_find(va[15:8], m_cur);
        ok  = (idx >= 0) && m_perm(idx, acc);
        if (dl) begin
            chk(req, "hit",   lk_hit,   ok);
            chk(req, "miss",  lk_miss,  idx < 0);
            chk(req, "fault", lk_fault, (idx >= 0) && !ok);
            chk(req, "paddr", lk_paddr, ok ? {m_pfn[idx], va[7:0]} : 0);
            chk(req, "way",   lk_way,   idx >= 0 ? idx : 0);
            chk(req, "dirty", lk_dirty, idx >= 0 ? m_d[idx] : 0);
            chk(req, "ref",   lk_ref,   idx >= 0 ? m_r[idx] : 0);
        end
        vic = -1;
        if (dr) begin
            vic = m_find(rv, rid);
            if (vic < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
            if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % N; end
        end
        @(posedge clk);
        if (dl && ok) begin m_r[idx] = 1; if (acc == 2'd1) m_d[idx] = 1; end
        if (fl) for (int i = 0; i < N; i++) m_v[i] = 0;
        if (dr) begin
            m_v[vic] = 1; m_d[vic] = 0; m_r[vic] = 0; m_w[vic] = rw; m_x[vic] = rx;
            m_vpn[vic] = rv; m_pfn[vic] = rp; m_pid[vic] = rid;
        end
        #1;
        lk_valid = 0; rf_valid = 0; flush_all = 0;
    endtask

    task automatic look(input bit [15:0] va, input bit [1:0] acc, input string req);
        cyc(1, va, acc, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic refill(input bit [7:0] rv, input bit [7:0] rp, input bit [3:0] rid,
                          input bit rw, input bit rx, input string req);
        cyc(0, 0, 0, 1, rv, rp, rid, rw, rx, 0, req);
    endtask

    task automatic set_pid(input bit [3:0] p);
        @(negedge clk); pid_we = 1; pid_in = p;
        @(posedge clk); m_cur = p;
        #1 pid_we = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: empty after reset, process register 0.
        for (int v = 0; v < 4; v++) look({v[7:0], 8'h3C}, 2'd0, "R1");
        set_pid(1);
        // R9: fill from lowest free slot.
        for (int i = 0; i < N; i++)
            refill(8'h10 + 8'(i * 5), 8'hA0 + 8'(i * 3), 4'd1, i[0], i[1], "R9");
        // R2 R3 R5 R6 R10: sweep pages and every access code.
        for (int v = 0; v < 64; v++)
            for (int a = 0; a < 4; a++)
                look({v[7:0], v[7:0] ^ 8'h5A}, a[1:0], "R2_R3_R5_R6_R10");
        // R8: other process sees nothing, then owns an evicting refill.
        set_pid(2);
        look(16'h1001, 2'd0, "R8");
        refill(8'h10, 8'h77, 4'd2, 1, 1, "R9");
        look(16'h1002, 2'd1, "R8");
        set_pid(1);
        look(16'h1003, 2'd0, "R8");
        look(16'h1504, 2'd0, "R8");
        // R9: same page and tag overwrites in place.
        refill(8'h15, 8'h99, 4'd1, 1, 0, "R9");
        look(16'h1505, 2'd1, "R9");
        look(16'h1506, 2'd2, "R5");
        // R9: rotating pointer continues.
        refill(8'h40, 8'h41, 4'd1, 0, 0, "R9");
        refill(8'h41, 8'h42, 4'd1, 0, 0, "R9");
        look(16'h4000, 2'd0, "R9");
        look(16'h4100, 2'd0, "R9");
        // R7: flush and refill in the same cycle.
        cyc(0, 0, 0, 1, 8'h50, 8'h55, 4'd1, 1, 1, 1, "R7");
        for (int v = 0; v < 96; v++) look({v[7:0], 8'h11}, 2'd0, "R7");
        refill(8'h60, 8'h66, 4'd1, 0, 1, "R9");
        look(16'h60F0, 2'd2, "R10");
        // R7: flush alone.
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
        look(16'h5000, 2'd0, "R7");
        look(16'h6000, 2'd0, "R7");
        // R11: lookup and refill of the same page share a cycle.
        cyc(1, 16'h7012, 2'd1, 1, 8'h70, 8'h07, 4'd1, 1, 0, 0, "R11");
        look(16'h7013, 2'd1, "R11");
        look(16'h7014, 2'd0, "R11");
        // R11: refill overrides a status update in the same cycle.
        cyc(1, 16'h7015, 2'd1, 1, 8'h70, 8'h08, 4'd1, 1, 0, 0, "R11");
        look(16'h7016, 2'd0, "R11");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule